// File: doc/BRIEF.md
# Local Interrupt Selector

This block decides, once per clock, whether a hart should take one of its local interrupts and, if so, which one. Each line has a pending bit, an enable bit and a delegation bit. A line is a candidate when it is both pending and enabled. A candidate then passes through one of two global gates, chosen by its delegation bit. The gates depend on the current privilege level and on the global machine and supervisor interrupt-enable bits.

Among the surviving candidates the lowest-numbered line wins. The block registers a take flag and a cause word. The cause word has an interrupt flag in its most significant bit and the winning line number in its low bits. Trap entry reads these registered outputs one cycle after the inputs were presented, so the priority search stays out of that path.

All pins are plain level signals sampled every cycle. There is no stream data and no handshake, so the block applies no back-pressure: a new decision is produced on every clock.

Top module: `irq_select`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `irq_take` is 0 and `irq_cause` is 0, whatever the other inputs are.
- R2: A line is a candidate only when both its `line_pend` bit and its `line_en` bit are 1. A pending line that is not enabled never wins.
- R3: The machine gate is open when `cur_priv` is below M (unsigned compare), or when it equals M and `glb_mie` is 1. Privilege encoding is U=2'b00, S=2'b01, M=2'b11.
- R4: The supervisor gate is open when `cur_priv` is U, or when it is S and `glb_sie` is 1. With `cur_priv` at M (or at the unused code 2'b10) the supervisor gate is closed.
- R5: A candidate whose `line_deleg` bit is 0 passes only through the machine gate. A candidate whose `line_deleg` bit is 1 passes only through the supervisor gate.
- R6: When several candidates pass their gates, the one with the lowest bit index is selected.
- R7: When no candidate passes, `irq_take` is 0 and `irq_cause` is all zeros.
- R8: When `irq_take` is 1, bit CAUSE_W-1 of `irq_cause` is 1. Bits IDX_W-1:0 hold the winning index, and all other bits are 0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. A change of input is not visible at the outputs before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_pend | input | NLINES | Pending bit of each interrupt line |
| line_en | input | NLINES | Enable bit of each interrupt line |
| line_deleg | input | NLINES | Delegation bit: 1 routes the line through the supervisor gate |
| cur_priv | input | 2 | Current privilege: U=0, S=1, M=3 |
| glb_mie | input | 1 | Global machine interrupt enable |
| glb_sie | input | 1 | Global supervisor interrupt enable |
| irq_take | output | 1 | Registered: an interrupt should be taken |
| irq_cause | output | CAUSE_W | Registered cause: flag in the MSB, index in the low bits |

## Verification
The bench targets privilege boundaries where an off-by-one in the comparisons changes the result. These are M with `glb_mie` low, S with `glb_sie` low, and delegated lines while running at M: a design that got these wrong would take an interrupt the hart must not see. It sets a delegated low line and a non-delegated high line together and checks that the gate, not the priority, decides the outcome. A design that applied the wrong gate would report the wrong cause. The all-ones and top-bit-only patterns catch a priority encoder that picks the highest line or drops the last index. A sample taken between an input change and the next edge catches a design that left the output unregistered.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate
  import irqsel_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic [NLINES-1:0] pend,
  input  logic [NLINES-1:0] en,
  input  logic [NLINES-1:0] deleg,
  input  logic [1:0]        priv,
  input  logic              mie,
  input  logic              sie,
  output logic [NLINES-1:0] cand
);
  logic m_open, s_open;

  assign m_open = (priv < PRIV_M) || ((priv == PRIV_M) && mie);
  assign s_open = (priv < PRIV_S) || ((priv == PRIV_S) && sie);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic gate_ok;
    assign gate_ok = deleg[g] ? s_open : m_open;
    assign cand[g] = pend[g] & en[g] & gate_ok;
  end

  // R2
  always_comb begin
    if (!$isunknown({pend, en, cand}))
      cand_subset_chk: assert ((cand & ~(pend & en)) == '0);
  end
endmodule

// File: rtl/irqsel_pri_enc.sv
module irqsel_pri_enc #(
  parameter int NLINES = 16,
  parameter int IDX_W  = 4
) (
  input  logic [NLINES-1:0] vec,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R6
  always_comb begin
    if (!$isunknown(vec) && found) begin
      win_set_chk: assert (vec[idx]);
      for (int j = 0; j < NLINES; j++) begin
        if (j < int'(idx))
          lower_clear_chk: assert (!vec[j]);
      end
    end
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irqsel_pkg::*;
#(
  parameter int NLINES  = 16,
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NLINES-1:0]  line_pend,
  input  logic [NLINES-1:0]  line_en,
  input  logic [NLINES-1:0]  line_deleg,
  input  logic [1:0]         cur_priv,
  input  logic               glb_mie,
  input  logic               glb_sie,
  output logic               irq_take,
  output logic [CAUSE_W-1:0] irq_cause
);
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic [NLINES-1:0]  cand;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  logic [CAUSE_W-1:0] cause_d;

  irqsel_gate #(.NLINES(NLINES)) u_gate (
    .pend(line_pend), .en(line_en), .deleg(line_deleg),
    .priv(cur_priv), .mie(glb_mie), .sie(glb_sie), .cand(cand)
  );

  irqsel_pri_enc #(.NLINES(NLINES), .IDX_W(IDX_W)) u_enc (
    .vec(cand), .found(found), .idx(win_idx)
  );

  always_comb begin
    cause_d = '0;
    if (found) begin
      cause_d[IDX_W-1:0]   = win_idx;
      cause_d[CAUSE_W-1]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_take  <= 1'b0;
      irq_cause <= '0;
    end else begin
      irq_take  <= found;
      irq_cause <= cause_d;
    end
  end

  // R7
  no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_pend & line_en) == '0) |=> !irq_take);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take |-> (irq_cause == '0));

  // R8
  cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_cause[CAUSE_W-1]);

  // R4
  deleg_at_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_priv == PRIV_M) && ((line_pend & line_en & ~line_deleg) == '0)) |=> !irq_take);

  // R3
  m_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_priv == PRIV_M) && !glb_mie) |=> !irq_take);
endmodule

// File: tb/irq_select_bench.sv
module irq_select_bench;
  localparam int N  = 16;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pend, en, deleg;
  logic [1:0]    priv;
  logic          mie, sie;
  logic          take;
  logic [CW-1:0] cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic          exp_take;
  logic [CW-1:0] exp_cause;

  always #5 clk = ~clk;

  irq_select #(.NLINES(N), .CAUSE_W(CW)) u_irq_select (
    .clk(clk), .rst_n(rst_n), .line_pend(pend), .line_en(en),
    .line_deleg(deleg), .cur_priv(priv), .glb_mie(mie), .glb_sie(sie),
    .irq_take(take), .irq_cause(cause)
  );

  function automatic logic [CW:0] model(logic [N-1:0] p, logic [N-1:0] e,
      logic [N-1:0] d, logic [1:0] pr, logic m, logic s);
    logic mok, sok;
    logic [N-1:0] c;
    logic [CW:0] r;
    mok = (pr == 2'b00) || (pr == 2'b01) || (pr == 2'b10) || ((pr == 2'b11) && m);
    sok = (pr == 2'b00) || ((pr == 2'b01) && s);
    c = p & e & ((~d & {N{mok}}) | (d & {N{sok}}));
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (c[i] && !r[CW]) begin
        r[CW] = 1'b1;
        r[CW-1:0] = (CW'(1) << (CW - 1)) | CW'(i);
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic et, logic [CW-1:0] ec);
    checks++;
    if (take !== et || cause !== ec) begin
      errors++;
      $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
               tag, take, cause, et, ec);
    end
  endtask

  task automatic apply(logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] d,
                       logic [1:0] pr, logic m, logic s);
    logic [CW:0] r;
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pr; mie = m; sie = s;
    r = model(p, e, d, pr, m, s);
    exp_take  = r[CW];
    exp_cause = r[CW-1:0];
  endtask

  task automatic step(string tag, logic [N-1:0] p, logic [N-1:0] e,
                      logic [N-1:0] d, logic [1:0] pr, logic m, logic s);
    apply(p, e, d, pr, m, s);
    @(negedge clk);
    check(tag, exp_take, exp_cause);
  endtask

  initial begin : main
    logic [N-1:0] rp, re, rd;
    logic [1:0]   rpr;
    logic         prev_t;
    logic [CW-1:0] prev_c;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    pend = '1; en = '1; deleg = '0; priv = 2'b00; mie = 1'b1; sie = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, '0);
    rst_n = 1'b1;
    pend = '0; en = '0;
    @(negedge clk);
    check("R1 after reset", 1'b0, '0);

    step("R2 pending not enabled", 16'h0008, 16'h0000, 16'h0000, 2'b00, 1'b0, 1'b0);
    step("R2 enabled not pending", 16'h0000, 16'h0008, 16'h0000, 2'b00, 1'b0, 1'b0);
    step("R2 pending and enabled", 16'h0008, 16'h0008, 16'h0000, 2'b00, 1'b0, 1'b0);
    check("R8 cause index 3", 1'b1, 32'h8000_0003);

    step("R3 M mie low", 16'h0010, 16'hFFFF, 16'h0000, 2'b11, 1'b0, 1'b1);
    step("R3 M mie high", 16'h0010, 16'hFFFF, 16'h0000, 2'b11, 1'b1, 1'b0);
    step("R3 S mie low", 16'h0010, 16'hFFFF, 16'h0000, 2'b01, 1'b0, 1'b0);
    step("R3 U mie low", 16'h0010, 16'hFFFF, 16'h0000, 2'b00, 1'b0, 1'b0);

    step("R4 S sie low", 16'h0020, 16'hFFFF, 16'hFFFF, 2'b01, 1'b1, 1'b0);
    step("R4 S sie high", 16'h0020, 16'hFFFF, 16'hFFFF, 2'b01, 1'b0, 1'b1);
    step("R4 U sie low", 16'h0020, 16'hFFFF, 16'hFFFF, 2'b00, 1'b0, 1'b0);
    step("R4 M sie high", 16'h0020, 16'hFFFF, 16'hFFFF, 2'b11, 1'b1, 1'b1);
    step("R4 priv 2 sie high", 16'h0020, 16'hFFFF, 16'hFFFF, 2'b10, 1'b1, 1'b1);

    step("R5 M picks non-delegated", 16'h0024, 16'hFFFF, 16'h0004, 2'b11, 1'b1, 1'b1);
    check("R5 cause 5", 1'b1, 32'h8000_0005);
    step("R5 S sie low picks non-delegated", 16'h0024, 16'hFFFF, 16'h0004, 2'b01, 1'b0, 1'b0);
    step("R5 U picks lower delegated", 16'h0024, 16'hFFFF, 16'h0004, 2'b00, 1'b0, 1'b0);

    step("R6 all lines", 16'hFFFF, 16'hFFFF, 16'h0000, 2'b00, 1'b0, 1'b0);
    check("R6 lowest is 0", 1'b1, 32'h8000_0000);
    step("R6 top line only", 16'h8000, 16'hFFFF, 16'h0000, 2'b00, 1'b0, 1'b0);
    check("R8 cause index 15", 1'b1, 32'h8000_000F);

    step("R7 none", 16'h0000, 16'hFFFF, 16'h0000, 2'b00, 1'b1, 1'b1);
    check("R7 cause zero", 1'b0, '0);

    // R9: output holds the old decision until the next edge
    step("R9 setup", 16'h0002, 16'hFFFF, 16'h0000, 2'b00, 1'b0, 1'b0);
    prev_t = take; prev_c = cause;
    apply(16'h0000, 16'h0000, 16'h0000, 2'b00, 1'b0, 1'b0);
    #1;
    check("R9 before edge", prev_t, prev_c);
    @(negedge clk);
    check("R9 after edge", 1'b0, '0);

    for (int k = 0; k < 400; k++) begin
      rp  = N'($urandom);
      re  = N'($urandom);
      rd  = N'($urandom);
      rpr = 2'($urandom);
      if (k % 4 == 0) rp = rp & (rp - 1'b1) & N'($urandom);
      step("R6 random", rp, re, rd, rpr, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected end before timeout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule